// File: doc/BRIEF.md
# Indirect Statistics Counter Bank

This block holds a bank of event counters for a network interface. Each counter has its own increment line, and that line adds one to the counter in any cycle where it is high. Software does not see the counters as a flat register map. It reaches them through two registers behind a one-cycle strobe interface. The control register sets a pointer, a direction (read or write) and a clear-after-read option. The data register is the window onto the counter that the pointer selects.

Each data access that the current direction allows moves the pointer to the next counter. A driver can therefore dump or preload a run of counters with one control write and a burst of data accesses. Counter updates that arrive from the event side in the same cycle as a software access are never lost. A counter cleared by a read in the same cycle as an event is left at one. A counter loaded by a write in the same cycle as an event holds the written value plus one.

Top module: `stat_counter_port`

## Requirements
- R1: After reset every counter is 0, the pointer is 0, the direction is read and clear-after-read is off, so a control register read returns 0x0000_0400.
- R2: A high `inc_i[i]` in a cycle adds one to counter i. Any number of counters can be incremented in the same cycle.
- R3: A control register write loads the pointer from bits 5:0, the direction from bit 8 (0 = read, 1 = write) and clear-after-read from bit 9, but only if bit 10 is 1. A control write with bit 10 clear is ignored. A control register read returns the pointer in bits 5:0, the direction in bit 8, clear-after-read in bit 9, a constant 1 in bit 10 and zeros elsewhere.
- R4: In read direction, a data register read returns the counter selected by the pointer, as that counter stood before the access. The value appears on `reg_rdata_o` in the cycle after the strobe.
- R5: In write direction, a data register write loads the written value into the counter selected by the pointer.
- R6: Each allowed data access advances the pointer by one, and the pointer wraps from 63 to 0.
- R7: In read direction with clear-after-read set, a data read leaves the counter it read at 0.
- R8: If a clearing read and an increment hit the same counter in the same cycle, that counter becomes 1.
- R9: If a data write and an increment hit the same counter in the same cycle, that counter becomes the written value plus one.
- R10: Data accesses in the wrong direction are ignored. A data read in write direction returns 0. Neither kind of wrong-direction access changes any counter or the pointer.
- R11: Counters wrap modulo 2^32, so an increment of 0xFFFF_FFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 64 | Per-counter increment events |
| reg_wr_i | input | 1 | Register write strobe, one cycle |
| reg_rd_i | input | 1 | Register read strobe, one cycle; ignored while reg_wr_i is high |
| reg_sel_i | input | 1 | 0 selects the control register, 1 selects the data register |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read strobe and held until the next read |

## Verification
The hardest cases to reach are the two collisions, where an event arrives in the same cycle as a clearing read or a data write to the same counter. A correct read of that counter alone cannot show them. The stimulus drives the increment line for the pointed-at counter in the same cycle as the data strobe. It then re-aims the pointer with a fresh control write and reads the counter back, so the retained one, or the written value plus one, becomes visible at the data port. Wrong-direction accesses are exposed the same way: the pointer is read back through the control register, and the target counter is read through the data register afterwards.

// File: rtl/stat_cnt_pkg.sv
package stat_cnt_pkg;

    localparam int REG_W        = 32;
    localparam int CCR_ADDR_W   = 6;
    localparam int CCR_MODE_BIT = 8;
    localparam int CCR_COR_BIT  = 9;
    localparam int CCR_KEY_BIT  = 10;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_mode_e;

    typedef struct packed {
        logic                  cor;
        acc_mode_e             mode;
        logic [CCR_ADDR_W-1:0] addr;
    } ccr_t;

    typedef struct packed {
        logic ccr_wr;
        logic ccr_rd;
        logic data_wr;
        logic data_rd;
    } bus_op_t;

    function automatic bus_op_t decode_op(input logic wr, input logic rd, input logic sel);
        bus_op_t op;
        op.ccr_wr  = wr & ~sel;
        op.data_wr = wr & sel;
        op.ccr_rd  = rd & ~wr & ~sel;
        op.data_rd = rd & ~wr & sel;
        return op;
    endfunction

    function automatic ccr_t ccr_unpack(input logic [REG_W-1:0] w);
        ccr_t c;
        c.addr = w[CCR_ADDR_W-1:0];
        c.mode = acc_mode_e'(w[CCR_MODE_BIT]);
        c.cor  = w[CCR_COR_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ccr_pack(input ccr_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CCR_ADDR_W-1:0] = c.addr;
        w[CCR_MODE_BIT]   = c.mode;
        w[CCR_COR_BIT]    = c.cor;
        w[CCR_KEY_BIT]    = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/stat_cnt_ctrl.sv
module stat_cnt_ctrl
    import stat_cnt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  wdata,
    output bus_op_t           op,
    output logic [ADDR_W-1:0] ptr,
    output acc_mode_e         mode,
    output logic              cor,
    output logic              hon_rd,
    output logic              hon_wr,
    output logic [REG_W-1:0]  ccr_word
);

    ccr_t new_ccr;
    ccr_t cur_ccr;
    logic load;

    assign op      = decode_op(reg_wr, reg_rd, reg_sel);
    assign new_ccr = ccr_unpack(wdata);
    assign load    = op.ccr_wr && wdata[CCR_KEY_BIT];
    assign hon_rd  = op.data_rd && (mode == ACC_READ);
    assign hon_wr  = op.data_wr && (mode == ACC_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            mode <= ACC_READ;
            cor  <= 1'b0;
        end else if (load) begin
            ptr  <= new_ccr.addr[ADDR_W-1:0];
            mode <= new_ccr.mode;
            cor  <= new_ccr.cor;
        end else if (hon_rd || hon_wr) begin
            ptr  <= ptr + 1'b1;
        end
    end

    always_comb begin
        cur_ccr.addr = CCR_ADDR_W'(ptr);
        cur_ccr.mode = mode;
        cur_ccr.cor  = cor;
        ccr_word     = ccr_pack(cur_ccr);
    end

endmodule

// File: rtl/stat_cnt_bank.sv
module stat_cnt_bank #(
    parameter int NUM_CNT = 64,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = $clog2(NUM_CNT)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CNT-1:0]            inc,
    input  logic [ADDR_W-1:0]             ptr,
    input  logic                          hon_wr,
    input  logic                          hon_clr,
    input  logic [CNT_W-1:0]              wdata,
    output logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic             hit;
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] q;

        assign hit = (ptr == ADDR_W'(i));

        always_comb begin
            base = q;
            if (hit && hon_wr)
                base = wdata;
            else if (hit && hon_clr)
                base = '0;
        end

        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= base + CNT_W'(inc[i]);
        end

        assign cnt[i] = q;
    end

endmodule

// File: rtl/stat_cnt_rdata.sv
module stat_cnt_rdata
    import stat_cnt_pkg::*;
#(
    parameter int NUM_CNT = 64,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = $clog2(NUM_CNT)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  bus_op_t                       op,
    input  logic                          hon_rd,
    input  logic [REG_W-1:0]              ccr_word,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    input  logic [ADDR_W-1:0]             ptr,
    output logic [REG_W-1:0]              rdata
);

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (op.ccr_rd)
            rdata <= ccr_word;
        else if (op.data_rd)
            rdata <= hon_rd ? REG_W'(cnt[ptr]) : '0;
    end

endmodule

// File: rtl/stat_counter_port.sv
module stat_counter_port
    import stat_cnt_pkg::*;
#(
    parameter int NUM_CNT = 64,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] inc_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic               reg_sel_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o
);

    localparam int ADDR_W = $clog2(NUM_CNT);

    bus_op_t                       op;
    logic [ADDR_W-1:0]             ptr;
    acc_mode_e                     mode;
    logic                          cor;
    logic                          hon_rd;
    logic                          hon_wr;
    logic                          hon_clr;
    logic [REG_W-1:0]              ccr_word;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

    assign hon_clr = hon_rd && cor;

    stat_cnt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr_i), .reg_rd(reg_rd_i), .reg_sel(reg_sel_i),
        .wdata(reg_wdata_i),
        .op(op), .ptr(ptr), .mode(mode), .cor(cor),
        .hon_rd(hon_rd), .hon_wr(hon_wr), .ccr_word(ccr_word)
    );

    stat_cnt_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst(rst), .inc(inc_i), .ptr(ptr),
        .hon_wr(hon_wr), .hon_clr(hon_clr),
        .wdata(reg_wdata_i[CNT_W-1:0]), .cnt(cnt)
    );

    stat_cnt_rdata #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rdata (
        .clk(clk), .rst(rst), .op(op), .hon_rd(hon_rd),
        .ccr_word(ccr_word), .cnt(cnt), .ptr(ptr), .rdata(reg_rdata_o)
    );

endmodule

// File: rtl/stat_counter_port_chk.sv
module stat_counter_port_chk
    import stat_cnt_pkg::*;
#(
    parameter int NUM_CNT = 64,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = $clog2(NUM_CNT)
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_CNT-1:0]            inc_i,
    input logic                          reg_wr_i,
    input logic                          reg_rd_i,
    input logic                          reg_sel_i,
    input logic [REG_W-1:0]              reg_wdata_i,
    input logic [REG_W-1:0]              reg_rdata_o,
    input logic [ADDR_W-1:0]             ptr,
    input acc_mode_e                     mode,
    input logic                          cor,
    input logic                          hon_rd,
    input logic                          hon_wr,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);

    logic [ADDR_W-1:0] prev_ptr;
    logic              clr_q;
    logic              clr_inc_q;
    logic              wr_inc_q;
    logic [CNT_W-1:0]  wdata_q;
    logic              bad_rd;
    logic              bad_key;

    assign bad_rd  = reg_rd_i && !reg_wr_i && reg_sel_i && (mode == ACC_WRITE);
    assign bad_key = reg_wr_i && !reg_sel_i && !reg_wdata_i[CCR_KEY_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ptr  <= '0;
            clr_q     <= 1'b0;
            clr_inc_q <= 1'b0;
            wr_inc_q  <= 1'b0;
            wdata_q   <= '0;
        end else begin
            prev_ptr  <= ptr;
            clr_q     <= hon_rd && cor && !inc_i[ptr];
            clr_inc_q <= hon_rd && cor && inc_i[ptr];
            wr_inc_q  <= hon_wr && inc_i[ptr];
            wdata_q   <= reg_wdata_i[CNT_W-1:0];
        end
    end

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hon_rd || hon_wr) && !(reg_wr_i && !reg_sel_i) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

    // R7
    cor_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_q |-> cnt[prev_ptr] == '0);

    // R8
    cor_collide_chk: assert property (@(posedge clk) disable iff (rst)
        clr_inc_q |-> cnt[prev_ptr] == CNT_W'(1));

    // R9
    wr_collide_chk: assert property (@(posedge clk) disable iff (rst)
        wr_inc_q |-> cnt[prev_ptr] == wdata_q + 1'b1);

    // R10
    bad_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bad_rd |=> reg_rdata_o == '0 && $stable(ptr));

    // R3
    key_guard_chk: assert property (@(posedge clk) disable iff (rst)
        bad_key |=> $stable(ptr) && $stable(mode) && $stable(cor));

endmodule

bind stat_counter_port stat_counter_port_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .inc_i(inc_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .ptr(ptr), .mode(mode), .cor(cor),
    .hon_rd(hon_rd), .hon_wr(hon_wr), .cnt(cnt)
);

// File: tb/stat_counter_port_tb.sv
module stat_counter_port_tb;

    localparam int NUM_CNT = 64;
    localparam logic [31:0] KEY  = 32'h0000_0400;
    localparam logic [31:0] WRM  = 32'h0000_0100;
    localparam logic [31:0] CORB = 32'h0000_0200;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_CNT-1:0] inc_i = '0;
    logic               reg_wr_i = 1'b0;
    logic               reg_rd_i = 1'b0;
    logic               reg_sel_i = 1'b0;
    logic [31:0]        reg_wdata_i = '0;
    logic [31:0]        reg_rdata_o;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    logic  armed  = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    stat_counter_port u_dut (
        .clk(clk), .rst(rst), .inc_i(inc_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
    );

    // monitor: a read strobe seen at an edge yields data checked at the next falling edge
    always @(posedge clk) armed <= reg_rd_i && !rst;

    always @(negedge clk) begin
        if (armed && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata_o !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", t, reg_rdata_o, e);
            end
        end
    end

    task automatic cyc(input logic wr, input logic rd, input logic sel,
                       input logic [31:0] wd, input logic [NUM_CNT-1:0] inc,
                       input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_wr_i    = wr;
        reg_rd_i    = rd;
        reg_sel_i   = sel;
        reg_wdata_i = wd;
        inc_i       = inc;
        if (rd) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        reg_wr_i = 1'b0;
        reg_rd_i = 1'b0;
        inc_i    = '0;
    endtask

    task automatic ccr_wr(input logic [31:0] v);
        cyc(1'b1, 1'b0, 1'b0, v, '0, '0, "");
    endtask
    task automatic ccr_rd(input logic [31:0] exp, input string tag);
        cyc(1'b0, 1'b1, 1'b0, '0, '0, exp, tag);
    endtask
    task automatic dat_wr(input logic [31:0] v, input logic [NUM_CNT-1:0] inc);
        cyc(1'b1, 1'b0, 1'b1, v, inc, '0, "");
    endtask
    task automatic dat_rd(input logic [31:0] exp, input logic [NUM_CNT-1:0] inc, input string tag);
        cyc(1'b0, 1'b1, 1'b1, '0, inc, exp, tag);
    endtask

    function automatic logic [NUM_CNT-1:0] bit_at(input int i);
        logic [NUM_CNT-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        ccr_rd(32'h0000_0400, "R1 control after reset");
        dat_rd(32'd0, '0, "R1 counter0 after reset");
        dat_rd(32'd0, '0, "R4 counter1 after reset");
        ccr_rd(32'h0000_0402, "R6 pointer advanced by reads");

        repeat (3) cyc(1'b0, 1'b0, 1'b0, '0, bit_at(0) | bit_at(5) | bit_at(63), '0, "");
        cyc(1'b0, 1'b0, 1'b0, '0, bit_at(5), '0, "");

        ccr_wr(KEY | 32'd63);
        dat_rd(32'd3, '0, "R2 counter63 events");
        dat_rd(32'd3, '0, "R6 wrap to counter0");
        ccr_rd(32'h0000_0401, "R6 pointer after wrap");
        ccr_wr(KEY | 32'd5);
        dat_rd(32'd4, '0, "R2 counter5 events");

        ccr_wr(WRM | 32'd20);
        ccr_rd(32'h0000_0406, "R3 control write without bit10 ignored");

        dat_wr(32'h0000_1234, '0);
        ccr_rd(32'h0000_0406, "R10 write in read mode keeps pointer");
        dat_rd(32'd0, '0, "R10 write in read mode keeps counter6");

        ccr_wr(KEY | WRM | 32'd62);
        dat_wr(32'hA0A0_0001, '0);
        dat_wr(32'hB0B0_0002, '0);
        dat_wr(32'hC0C0_0003, '0);
        dat_rd(32'd0, '0, "R10 read in write mode returns zero");
        ccr_rd(32'h0000_0501, "R10 read in write mode keeps pointer");

        ccr_wr(KEY | 32'd62);
        dat_rd(32'hA0A0_0001, '0, "R5 counter62 written");
        dat_rd(32'hB0B0_0002, '0, "R5 counter63 written");
        dat_rd(32'hC0C0_0003, '0, "R6 write burst wrapped to counter0");

        ccr_wr(KEY | CORB | 32'd5);
        ccr_rd(32'h0000_0605, "R3 control readback with clear flag");
        dat_rd(32'd4, '0, "R7 clearing read returns value");
        ccr_wr(KEY | CORB | 32'd5);
        dat_rd(32'd0, '0, "R7 counter5 cleared");

        ccr_wr(KEY | WRM | 32'd7);
        dat_wr(32'd100, '0);
        ccr_wr(KEY | CORB | 32'd7);
        dat_rd(32'd100, bit_at(7), "R8 clearing read with event returns old");
        ccr_wr(KEY | 32'd7);
        dat_rd(32'd1, '0, "R8 counter7 left at one");

        ccr_wr(KEY | WRM | 32'd20);
        dat_wr(32'd50, bit_at(20));
        ccr_wr(KEY | 32'd20);
        dat_rd(32'd51, '0, "R9 write with event");

        ccr_wr(KEY | WRM | 32'd30);
        dat_wr(32'hFFFF_FFFF, '0);
        cyc(1'b0, 1'b0, 1'b0, '0, bit_at(30), '0, "");
        ccr_wr(KEY | 32'd30);
        dat_rd(32'd0, '0, "R11 counter wraps to zero");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule